// File: doc/BRIEF.md
# ECC Error Status and Capture Registers

This block sits beside a memory controller's ECC decoder and its address-range checker. It turns their one-cycle event strobes into readable state. There are four kinds of event: a correctable ECC error, an uncorrectable ECC error, an access outside the populated memory space, and the end of memory initialization. For each error class the block records two things. The first is whether one event has been seen. The second is whether a further event arrived after that one. On the first event of a class it also captures the failing address. For the two ECC classes it also captures the 64-bit failing data and the 8-bit syndrome.

Software reads every register through a small register port. The read path is combinational. Software clears status bits by writing ones to the status offset. An 8-bit mask register selects which status bits may drive the level-sensitive interrupt output. A cleared class is ready to capture again, so software can service one event, acknowledge it and wait for the next.

Top module: `ecc_err_status`

## Requirements
- R1: After synchronous reset, status reads 0x00, the mask reads 0xFF (all sources masked), every capture register reads 0, and `irq` is low.
- R2: An event whose class "first" bit is clear sets that bit one clock later. The status bit positions are: out-of-range bit 0, correctable bit 2, uncorrectable bit 4.
- R3: An event whose class "first" bit is already set sets the class "repeat" bit: out-of-range bit 1, correctable bit 3, uncorrectable bit 5.
- R4: An initialization-done strobe sets status bit 6. Any correctable or uncorrectable strobe also sets status bit 7. A lone correctable event therefore reads 0x84 and a lone uncorrectable event reads 0x90. Simultaneous strobes of all four kinds from a clear state read 0xD5.
- R5: The first event of a class captures state into registers, read at these offsets:
  - the address, low 32 bits: out-of-range 0x3, correctable 0x5, uncorrectable 0x9;
  - the address, bit 32 in bit 0: out-of-range 0x4, correctable 0x6, uncorrectable 0xA;
  - the data, low 32 bits: correctable 0x7, uncorrectable 0xB;
  - the data, high 32 bits: correctable 0x8, uncorrectable 0xC;
  - the syndrome at offset 0x2: correctable in bits 23:16, uncorrectable in bits 15:8.
- R6: An event that arrives while its class "first" bit is set leaves that class's captured address, data and syndrome unchanged.
- R7: Writing to offset 0x0 clears exactly the status bits written as one and leaves the others. Writing 0xFF clears all of them.
- R8: If an event and the clearing write of its class "first" bit land in the same cycle, the event wins. The "first" bit stays set, the "repeat" bit is not set by that event, and the capture registers load the new event.
- R9: The mask register sits at offset 0x1, with 8 bits; a one masks the matching status bit. `irq` is high exactly when some status bit is set and its mask bit is clear.
- R10: Reads of offsets 0xD to 0xF return 0. Writes to any offset other than 0x0 and 0x1 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_oob | input | 1 | One-cycle strobe: access outside memory space |
| ev_corr | input | 1 | One-cycle strobe: correctable ECC error |
| ev_uncorr | input | 1 | One-cycle strobe: uncorrectable ECC error |
| ev_init | input | 1 | One-cycle strobe: memory initialization finished |
| ev_addr | input | 33 | Failing address that goes with the strobes |
| ev_data | input | 64 | Failing data that goes with the ECC strobes |
| ev_syn | input | 8 | ECC syndrome that goes with the ECC strobes |
| reg_wr_en | input | 1 | Register write enable |
| reg_addr | input | 4 | Register offset for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Interrupt, level, high when an unmasked status bit is set |

## Verification
The bench first triggers a second event while a class is already flagged. A design that recaptured on every event would overwrite the first address and syndrome. The bench then lands an acknowledge and a new event of the same class in the same cycle. A design that gave the clear priority would drop the event, and one that sampled the old bit would wrongly raise the repeat flag. The bench also acknowledges bits one at a time and checks that neighbouring bits and the other class's syndrome lane survive. It writes to read-only and unused offsets, and toggles single mask bits to show that `irq` follows only the unmasked status bits.

// File: rtl/ecc_stat_pkg.sv
package ecc_stat_pkg;

    parameter int ADDR_W  = 33;
    parameter int DATA_W  = 64;
    parameter int SYN_W   = 8;
    parameter int WORD_W  = 32;
    parameter int REG_AW  = 4;
    parameter int STAT_W  = 8;
    parameter int N_CLASS = 3;

    localparam int ADDR_HI_W    = ADDR_W - WORD_W;
    localparam int DATA_HI_W    = DATA_W - WORD_W;
    localparam int SYN_CORR_LSB = 16;
    localparam int SYN_UNC_LSB  = 8;
    localparam int BIT_INIT     = 6;
    localparam int BIT_ANY_ECC  = 7;

    // class index also fixes the status bit pair: first = 2*idx, repeat = 2*idx+1
    typedef enum int {
        CLS_OOB  = 0,
        CLS_CORR = 1,
        CLS_UNC  = 2
    } err_class_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [SYN_W-1:0]  syn;
    } capture_t;

    typedef enum logic [REG_AW-1:0] {
        RA_STATUS  = 4'h0,
        RA_MASK    = 4'h1,
        RA_SYN     = 4'h2,
        RA_OOB_ALO = 4'h3,
        RA_OOB_AHI = 4'h4,
        RA_COR_ALO = 4'h5,
        RA_COR_AHI = 4'h6,
        RA_COR_DLO = 4'h7,
        RA_COR_DHI = 4'h8,
        RA_UNC_ALO = 4'h9,
        RA_UNC_AHI = 4'hA,
        RA_UNC_DLO = 4'hB,
        RA_UNC_DHI = 4'hC
    } reg_addr_e;

    function automatic int first_bit(input int cls);
        return 2 * cls;
    endfunction

    function automatic logic [WORD_W-1:0] addr_hi_word(input logic [ADDR_W-1:0] a);
        return WORD_W'(a[ADDR_W-1:WORD_W]);
    endfunction

    function automatic logic [WORD_W-1:0] data_hi_word(input logic [DATA_W-1:0] d);
        return WORD_W'(d[DATA_W-1:WORD_W]);
    endfunction

endpackage

// File: rtl/ecc_class_track.sv
module ecc_class_track
    import ecc_stat_pkg::*;
#(
    parameter bit KEEP_DATA = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     ev,
    input  logic     clr_first,
    input  logic     clr_repeat,
    input  capture_t sample,
    output logic     first_q,
    output logic     repeat_q,
    output capture_t cap_q
);

    localparam capture_t KEEP_MASK =
        {{ADDR_W{1'b1}}, {DATA_W{KEEP_DATA}}, {SYN_W{KEEP_DATA}}};

    logic     first_base;
    logic     load;
    capture_t kept;

    // acknowledge applies first, then the event is judged against the result
    always_comb begin
        first_base = first_q & ~clr_first;
        load       = ev & ~first_base;
        kept       = sample & KEEP_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q  <= 1'b0;
            repeat_q <= 1'b0;
        end else begin
            first_q  <= first_base | ev;
            repeat_q <= (repeat_q & ~clr_repeat) | (ev & first_base);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else if (load) begin
            cap_q <= kept;
        end
    end

endmodule

// File: rtl/ecc_reg_read.sv
module ecc_reg_read
    import ecc_stat_pkg::*;
(
    input  logic [REG_AW-1:0] rd_addr,
    input  logic [STAT_W-1:0] stat,
    input  logic [STAT_W-1:0] mask,
    input  capture_t          caps [N_CLASS],
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] syn_word;

    always_comb begin
        syn_word = '0;
        syn_word[SYN_CORR_LSB +: SYN_W] = caps[CLS_CORR].syn;
        syn_word[SYN_UNC_LSB  +: SYN_W] = caps[CLS_UNC].syn;
    end

    always_comb begin
        case (rd_addr)
            RA_STATUS:  rd_data = WORD_W'(stat);
            RA_MASK:    rd_data = WORD_W'(mask);
            RA_SYN:     rd_data = syn_word;
            RA_OOB_ALO: rd_data = caps[CLS_OOB].addr[WORD_W-1:0];
            RA_OOB_AHI: rd_data = addr_hi_word(caps[CLS_OOB].addr);
            RA_COR_ALO: rd_data = caps[CLS_CORR].addr[WORD_W-1:0];
            RA_COR_AHI: rd_data = addr_hi_word(caps[CLS_CORR].addr);
            RA_COR_DLO: rd_data = caps[CLS_CORR].data[WORD_W-1:0];
            RA_COR_DHI: rd_data = data_hi_word(caps[CLS_CORR].data);
            RA_UNC_ALO: rd_data = caps[CLS_UNC].addr[WORD_W-1:0];
            RA_UNC_AHI: rd_data = addr_hi_word(caps[CLS_UNC].addr);
            RA_UNC_DLO: rd_data = caps[CLS_UNC].data[WORD_W-1:0];
            RA_UNC_DHI: rd_data = data_hi_word(caps[CLS_UNC].data);
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ecc_err_status.sv
module ecc_err_status
    import ecc_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_oob,
    input  logic              ev_corr,
    input  logic              ev_uncorr,
    input  logic              ev_init,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_data,
    input  logic [SYN_W-1:0]  ev_syn,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq
);

    logic [STAT_W-1:0]  stat_q;
    logic [STAT_W-1:0]  mask_q;
    logic [STAT_W-1:0]  clr;
    logic [N_CLASS-1:0] ev_vec;
    logic [N_CLASS-1:0] first_v;
    logic [N_CLASS-1:0] repeat_v;
    capture_t           cap_v [N_CLASS];
    capture_t           sample;
    logic               init_q;
    logic               any_ecc_q;

    always_comb begin
        clr    = (reg_wr_en && reg_addr == RA_STATUS) ? reg_wdata : '0;
        sample = '{addr: ev_addr, data: ev_data, syn: ev_syn};
        ev_vec = '0;
        ev_vec[CLS_OOB]  = ev_oob;
        ev_vec[CLS_CORR] = ev_corr;
        ev_vec[CLS_UNC]  = ev_uncorr;
    end

    for (genvar g = 0; g < N_CLASS; g++) begin : g_cls
        ecc_class_track #(
            .KEEP_DATA (g != CLS_OOB)
        ) u_trk (
            .clk        (clk),
            .rst        (rst),
            .ev         (ev_vec[g]),
            .clr_first  (clr[2*g]),
            .clr_repeat (clr[2*g+1]),
            .sample     (sample),
            .first_q    (first_v[g]),
            .repeat_q   (repeat_v[g]),
            .cap_q      (cap_v[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            init_q    <= 1'b0;
            any_ecc_q <= 1'b0;
            mask_q    <= '1;
        end else begin
            init_q    <= (init_q & ~clr[BIT_INIT]) | ev_init;
            any_ecc_q <= (any_ecc_q & ~clr[BIT_ANY_ECC]) | ev_corr | ev_uncorr;
            if (reg_wr_en && reg_addr == RA_MASK) begin
                mask_q <= reg_wdata;
            end
        end
    end

    always_comb begin
        stat_q = '0;
        for (int c = 0; c < N_CLASS; c++) begin
            stat_q[first_bit(c)]     = first_v[c];
            stat_q[first_bit(c) + 1] = repeat_v[c];
        end
        stat_q[BIT_INIT]    = init_q;
        stat_q[BIT_ANY_ECC] = any_ecc_q;
    end

    assign irq = |(stat_q & ~mask_q);

    ecc_reg_read u_rd (
        .rd_addr (reg_addr),
        .stat    (stat_q),
        .mask    (mask_q),
        .caps    (cap_v),
        .rd_data (reg_rdata)
    );

endmodule

// File: rtl/ecc_err_status_chk.sv
module ecc_err_status_chk
    import ecc_stat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ev_oob,
    input logic              ev_corr,
    input logic              ev_uncorr,
    input logic              ev_init,
    input logic [ADDR_W-1:0] ev_addr,
    input logic              reg_wr_en,
    input logic [REG_AW-1:0] reg_addr,
    input logic [STAT_W-1:0] reg_wdata,
    input logic [STAT_W-1:0] stat_q,
    input logic [STAT_W-1:0] mask_q,
    input logic              irq,
    input logic [ADDR_W-1:0] corr_cap_addr
);

    logic              st_wr;
    logic [STAT_W-1:0] ack;
    logic              no_ev;

    always_comb begin
        st_wr = reg_wr_en && (reg_addr == RA_STATUS);
        ack   = st_wr ? reg_wdata : '0;
        no_ev = !(ev_oob || ev_corr || ev_uncorr || ev_init);
    end

    p_first_set_r2: assert property (@(posedge clk) disable iff (rst)
        ev_corr |=> stat_q[2]);

    p_repeat_set_r3: assert property (@(posedge clk) disable iff (rst)
        (ev_uncorr && stat_q[4] && !ack[4]) |=> stat_q[5]);

    p_ecc_any_r4: assert property (@(posedge clk) disable iff (rst)
        (ev_corr || ev_uncorr) |=> stat_q[7]);

    p_capture_first_r5: assert property (@(posedge clk) disable iff (rst)
        (ev_corr && !(stat_q[2] && !ack[2])) |=> (corr_cap_addr == $past(ev_addr)));

    p_capture_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (ev_corr && stat_q[2] && !ack[2]) |=> $stable(corr_cap_addr));

    p_clear_all_r7: assert property (@(posedge clk) disable iff (rst)
        (st_wr && reg_wdata == '1 && no_ev) |=> (stat_q == '0));

    p_race_event_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (ev_corr && stat_q[2] && ack[2] && !stat_q[3]) |=> (stat_q[2] && !stat_q[3]));

    p_masked_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '1) |-> !irq);

endmodule

bind ecc_err_status ecc_err_status_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ev_oob        (ev_oob),
    .ev_corr       (ev_corr),
    .ev_uncorr     (ev_uncorr),
    .ev_init       (ev_init),
    .ev_addr       (ev_addr),
    .reg_wr_en     (reg_wr_en),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .stat_q        (stat_q),
    .mask_q        (mask_q),
    .irq           (irq),
    .corr_cap_addr (cap_v[1].addr)
);

// File: tb/ecc_err_status_test.sv
module ecc_err_status_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        ev_oob, ev_corr, ev_uncorr, ev_init;
    logic [32:0] ev_addr;
    logic [63:0] ev_data;
    logic [7:0]  ev_syn;
    logic        reg_wr_en;
    logic [3:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    logic [7:0]  m_stat = 8'h00;
    logic [7:0]  m_mask = 8'hFF;
    logic [32:0] m_addr [3];
    logic [63:0] m_data [3];
    logic [7:0]  m_syn  [3];

    always #5 clk = ~clk;

    ecc_err_status uut (
        .clk(clk), .rst(rst),
        .ev_oob(ev_oob), .ev_corr(ev_corr), .ev_uncorr(ev_uncorr), .ev_init(ev_init),
        .ev_addr(ev_addr), .ev_data(ev_data), .ev_syn(ev_syn),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            4'h0: return {24'h0, m_stat};
            4'h1: return {24'h0, m_mask};
            4'h2: return {8'h00, m_syn[1], m_syn[2], 8'h00};
            4'h3: return m_addr[0][31:0];
            4'h4: return {31'h0, m_addr[0][32]};
            4'h5: return m_addr[1][31:0];
            4'h6: return {31'h0, m_addr[1][32]};
            4'h7: return m_data[1][31:0];
            4'h8: return m_data[1][63:32];
            4'h9: return m_addr[2][31:0];
            4'hA: return {31'h0, m_addr[2][32]};
            4'hB: return m_data[2][31:0];
            4'hC: return m_data[2][63:32];
            default: return 32'h0;
        endcase
    endfunction

    // reference model stepped every clock, outputs compared 3 ns later
    always @(posedge clk) begin
        logic [7:0] nxt;
        logic [2:0] evs;
        evs = {ev_uncorr, ev_corr, ev_oob};
        if (rst) begin
            m_stat = 8'h00;
            m_mask = 8'hFF;
            for (int c = 0; c < 3; c++) begin
                m_addr[c] = '0; m_data[c] = '0; m_syn[c] = '0;
            end
        end else begin
            nxt = m_stat;
            if (reg_wr_en && reg_addr == 4'h0) nxt = nxt & ~reg_wdata;
            if (reg_wr_en && reg_addr == 4'h1) m_mask = reg_wdata;
            for (int c = 0; c < 3; c++) begin
                if (evs[c]) begin
                    if (!nxt[2*c]) begin
                        nxt[2*c]  = 1'b1;
                        m_addr[c] = ev_addr;
                        m_data[c] = (c == 0) ? 64'h0 : ev_data;
                        m_syn[c]  = (c == 0) ? 8'h0 : ev_syn;
                    end else begin
                        nxt[2*c+1] = 1'b1;
                    end
                end
            end
            if (ev_init) nxt[6] = 1'b1;
            if (ev_corr || ev_uncorr) nxt[7] = 1'b1;
            m_stat = nxt;
        end
        #3;
        checks++;
        if (reg_rdata !== model_read(reg_addr)) begin
            fails++;
            $display("FAIL R10 per-cycle read offset %0h: actual %h expected %h",
                     reg_addr, reg_rdata, model_read(reg_addr));
        end
        checks++;
        if (irq !== |(m_stat & ~m_mask)) begin
            fails++;
            $display("FAIL R9 per-cycle irq: actual %b expected %b",
                     irq, |(m_stat & ~m_mask));
        end
    end

    task automatic chk_reg(input logic [3:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            fails++;
            $display("FAIL %s offset %0h: actual %h expected %h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string req);
        @(negedge clk);
        #1;
        checks++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s irq: actual %b expected %b", req, irq, exp);
        end
    endtask

    // cls: 0 out-of-range, 1 correctable, 2 uncorrectable, 3 init; wr_ack puts a status write in the same cycle
    task automatic fire(input int cls, input logic [32:0] a, input logic [63:0] d,
                        input logic [7:0] s, input bit wr_ack, input logic [7:0] ackv);
        @(negedge clk);
        ev_oob    = (cls == 0);
        ev_corr   = (cls == 1);
        ev_uncorr = (cls == 2);
        ev_init   = (cls == 3);
        ev_addr = a; ev_data = d; ev_syn = s;
        if (wr_ack) begin
            reg_wr_en = 1'b1; reg_addr = 4'h0; reg_wdata = ackv;
        end
        @(negedge clk);
        ev_oob = 0; ev_corr = 0; ev_uncorr = 0; ev_init = 0;
        reg_wr_en = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        ev_oob = 0; ev_corr = 0; ev_uncorr = 0; ev_init = 0;
        ev_addr = '0; ev_data = '0; ev_syn = '0;
        reg_wr_en = 0; reg_addr = 4'h0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_reg(4'h0, 32'h0, "R1");
        chk_reg(4'h1, 32'hFF, "R1");
        chk_reg(4'h5, 32'h0, "R1");
        chk_irq(1'b0, "R1");

        // R2 R4 R5 first correctable event
        fire(1, 33'h1_0000_0040, 64'hDEAD_BEEF_0101_0101, 8'hE9, 0, 8'h0);
        chk_reg(4'h0, 32'h84, "R2/R4");
        chk_reg(4'h2, 32'h00E9_0000, "R5");
        chk_reg(4'h5, 32'h0000_0040, "R5");
        chk_reg(4'h6, 32'h1, "R5");
        chk_reg(4'h7, 32'h0101_0101, "R5");
        chk_reg(4'h8, 32'hDEAD_BEEF, "R5");

        // R3 R6 second correctable event
        fire(1, 33'h0_0000_0080, 64'h1, 8'h0B, 0, 8'h0);
        chk_reg(4'h0, 32'h8C, "R3");
        chk_reg(4'h5, 32'h0000_0040, "R6");
        chk_reg(4'h2, 32'h00E9_0000, "R6");

        // R9 mask control
        chk_irq(1'b0, "R9");
        wr(4'h1, 8'hF7);
        chk_irq(1'b1, "R9");
        wr(4'h1, 8'hFF);
        chk_irq(1'b0, "R9");

        // R7 single-bit acknowledge, then recapture
        wr(4'h0, 8'h04);
        chk_reg(4'h0, 32'h88, "R7");
        fire(1, 33'h0_0000_0100, 64'h2, 8'h16, 0, 8'h0);
        chk_reg(4'h0, 32'h8C, "R2");
        chk_reg(4'h5, 32'h0000_0100, "R5");
        chk_reg(4'h6, 32'h0, "R5");
        wr(4'h0, 8'hFF);
        chk_reg(4'h0, 32'h0, "R7");

        // R4 R5 uncorrectable event, lane separate from correctable
        fire(2, 33'h1_0000_0200, 64'h6101_0101_0000_0003, 8'h3C, 0, 8'h0);
        chk_reg(4'h0, 32'h90, "R4");
        chk_reg(4'h2, 32'h0016_3C00, "R5");
        chk_reg(4'h9, 32'h0000_0200, "R5");
        chk_reg(4'hA, 32'h1, "R5");
        chk_reg(4'hB, 32'h0000_0003, "R5");
        chk_reg(4'hC, 32'h6101_0101, "R5");

        // R8 acknowledge and event in the same cycle
        fire(2, 33'h0_0000_0300, 64'h4, 8'h55, 1, 8'h10);
        chk_reg(4'h0, 32'h90, "R8");
        chk_reg(4'h9, 32'h0000_0300, "R8");
        chk_reg(4'h2, 32'h0016_5500, "R8");

        // R2 R3 R6 out-of-range class
        fire(0, 33'h0_1234_5678, 64'h0, 8'h0, 0, 8'h0);
        chk_reg(4'h0, 32'h91, "R2");
        chk_reg(4'h3, 32'h1234_5678, "R5");
        chk_reg(4'h4, 32'h0, "R5");
        fire(0, 33'h1_0000_0777, 64'h0, 8'h0, 0, 8'h0);
        chk_reg(4'h0, 32'h93, "R3");
        chk_reg(4'h3, 32'h1234_5678, "R6");

        // R4 init done
        fire(3, 33'h0, 64'h0, 8'h0, 0, 8'h0);
        chk_reg(4'h0, 32'hD3, "R4");

        // R9 single unmasked bit
        wr(4'h1, 8'hFE);
        chk_reg(4'h1, 32'hFE, "R9");
        chk_irq(1'b1, "R9");
        wr(4'h1, 8'hFF);

        // R10 read-only and unused offsets
        wr(4'h9, 8'hAB);
        chk_reg(4'h9, 32'h0000_0300, "R10");
        wr(4'hF, 8'h12);
        chk_reg(4'hF, 32'h0, "R10");
        chk_reg(4'hD, 32'h0, "R10");
        chk_reg(4'h0, 32'hD3, "R10");

        // R4 all strobes together from clear
        wr(4'h0, 8'hFF);
        @(negedge clk);
        ev_oob = 1; ev_corr = 1; ev_uncorr = 1; ev_init = 1;
        ev_addr = 33'h0_0000_0900; ev_data = 64'h9; ev_syn = 8'h77;
        @(negedge clk);
        ev_oob = 0; ev_corr = 0; ev_uncorr = 0; ev_init = 0;
        chk_reg(4'h0, 32'hD5, "R4");
        chk_reg(4'h2, 32'h0077_7700, "R5");

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule